// File: doc/BRIEF.md
# BIST Frame Generator

This block produces a self-test traffic stream for a four-lane parallel interface. A frame has an overhead of twelve A1 bytes (0xF6), then twelve A2 bytes (0x28), then 9696 bytes of a 2^7-1 pseudorandom sequence. That makes 9720 bytes per frame, and frames repeat with no gap. In test mode the stream takes the place of the external lane inputs. Every lane carries the same bytes, and each lane lags its lower neighbour by one beat. The downstream loopback and checking logic can then show that it tolerates skew between lanes and still finds the frame.

The lane bytes leave through a valid/ready interface. A beat is transferred on a clock edge where `out_valid` and `out_ready` are both high. While `out_ready` is low the block holds every lane byte and the frame-start flag unchanged, and it neither advances the frame position nor the pseudorandom state. `out_valid` depends only on the control inputs and never waits on `out_ready`. Two control pins are active low: test enable and frame restart. Both are sampled on the clock.

Top module: `bist_frame_gen`

## Requirements
- R1: While `rst_n` is low, `out_valid` and `out_sof` are 0 and `lane_data` is all zeros.
- R2: `out_valid` rises one cycle after `test_n` is sampled low with `frame_rst_n` high. It falls one cycle after `test_n` is sampled high.
- R3: On lane 0, the beats of each frame are 12 beats of 0xF6, then 12 beats of 0x28, then 9696 payload beats. The pattern repeats every 9720 accepted beats.
- R4: The payload comes from a 7-bit LFSR with polynomial x^7+x^6+1, seeded to 0x7F. Each step emits the bit s[6] XOR s[5] and shifts that bit in at s[0]. Eight steps make one byte, and the first bit emitted goes to bit 7. The LFSR steps only for payload beats and carries on from frame to frame, so the first payload byte after a start is 0x02.
- R5: Lane k occupies `lane_data[8k+7:8k]`. On every accepted beat n it carries the byte that lane 0 carried on beat n-k. When n < k it carries 0x00.
- R6: `out_sof` is high exactly on the valid beats where lane 0 carries the first A1 byte of a frame.
- R7: While `out_valid` is high and `out_ready` is low, `lane_data` and `out_sof` hold their values. The stream advances only on beats that are accepted.
- R8: Sampling `frame_rst_n` low drops `out_valid` on the next cycle and holds it low for as long as the pin stays low. When the pin is released with `test_n` low, the stream restarts at the frame start. The LFSR returns to its seed and lanes 1 to 3 are cleared.
- R9: Whenever `out_valid` is low, `lane_data` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_n | input | 1 | Active-low test mode enable |
| frame_rst_n | input | 1 | Active-low frame restart |
| out_ready | input | 1 | Downstream accepts the current beat |
| out_valid | output | 1 | A beat is presented |
| lane_data | output | 32 | Lane bytes, lane k in bits 8k+7:8k |
| out_sof | output | 1 | First A1 byte of a frame is on lane 0 |

## Verification
The first pattern keeps `out_ready` high for more than two full frames. It checks every lane byte against an independent model of the frame layout and the LFSR. This separates errors in the overhead counts, the payload taps, bit order and continuity from frame to frame, and the depth of the lane stagger. The second pattern drops `out_ready` on one beat in three for over a frame. It shows whether stalls freeze the outputs and the pseudorandom state or instead slip bytes. The last two patterns restart the frame in mid-payload and toggle test enable. They show whether restarts reseed and clear the lanes and whether the idle outputs are forced to zero.

// File: rtl/bist_pkg.sv
package bist_pkg;

  typedef struct packed {
    logic [7:0] byte_v;
    logic [6:0] state;
  } prbs_step_t;

  // Eight LFSR steps, first emitted bit lands in bit 7.
  function automatic prbs_step_t prbs7_byte(input logic [6:0] s_in);
    prbs_step_t r;
    logic [6:0] s;
    logic fb;
    s = s_in;
    r.byte_v = '0;
    for (int i = 7; i >= 0; i--) begin
      fb = s[6] ^ s[5];
      r.byte_v[i] = fb;
      s = {s[5:0], fb};
    end
    r.state = s;
    return r;
  endfunction

endpackage

// File: rtl/bist_prbs7.sv
module bist_prbs7 #(
  parameter logic [6:0] SEED = 7'h7F
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       adv,
  output logic [7:0] byte_o
);
  import bist_pkg::*;

  logic [6:0] state_q;
  prbs_step_t nxt;

  always_comb nxt = prbs7_byte(state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      state_q <= SEED;
    else if (clr)    state_q <= SEED;
    else if (adv)    state_q <= nxt.state;
  end

  assign byte_o = nxt.byte_v;
endmodule

// File: rtl/bist_frame_seq.sv
module bist_frame_seq #(
  parameter int         N_A1  = 12,
  parameter int         N_A2  = 12,
  parameter int         N_PAY = 9696,
  parameter logic [7:0] A1    = 8'hF6,
  parameter logic [7:0] A2    = 8'h28
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       adv,
  input  logic [7:0] pay_byte,
  output logic [7:0] byte_o,
  output logic       pay_o,
  output logic       start_o
);
  localparam int FRAME = N_A1 + N_A2 + N_PAY;
  localparam int IW    = $clog2(FRAME);
  localparam logic [IW-1:0] LAST   = IW'(FRAME - 1);
  localparam logic [IW-1:0] A2_BEG = IW'(N_A1);
  localparam logic [IW-1:0] PY_BEG = IW'(N_A1 + N_A2);

  logic [IW-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         idx_q <= '0;
    else if (clr)       idx_q <= '0;
    else if (adv)       idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
  end

  always_comb begin
    pay_o = (idx_q >= PY_BEG);
    if (idx_q < A2_BEG)   byte_o = A1;
    else if (!pay_o)      byte_o = A2;
    else                  byte_o = pay_byte;
  end

  assign start_o = (idx_q == '0);
endmodule

// File: rtl/bist_lane_skew.sv
module bist_lane_skew #(
  parameter int LANES = 4,
  parameter int W     = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               adv,
  input  logic [W-1:0]       din,
  output logic [LANES*W-1:0] dout
);
  logic [W-1:0] stage [LANES];

  assign stage[0] = din;

  for (genvar k = 1; k < LANES; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stage[k] <= '0;
      else if (clr)    stage[k] <= '0;
      else if (adv)    stage[k] <= stage[k-1];
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_out
    assign dout[k*W +: W] = stage[k];
  end
endmodule

// File: rtl/bist_frame_gen.sv
module bist_frame_gen #(
  parameter int         LANES = 4,
  parameter int         N_A1  = 12,
  parameter int         N_A2  = 12,
  parameter int         N_PAY = 9696,
  parameter logic [7:0] A1    = 8'hF6,
  parameter logic [7:0] A2    = 8'h28,
  parameter logic [6:0] SEED  = 7'h7F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             test_n,
  input  logic             frame_rst_n,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [LANES*8-1:0] lane_data,
  output logic             out_sof
);
  logic run_q;
  logic clr, adv, pay, start;
  logic [7:0] pay_byte, lane0;
  logic [LANES*8-1:0] skewed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= !test_n && frame_rst_n;
  end

  assign clr = !run_q;
  assign adv = run_q && out_ready;

  bist_prbs7 #(.SEED(SEED)) u_prbs (
    .clk(clk), .rst_n(rst_n), .clr(clr), .adv(adv && pay), .byte_o(pay_byte)
  );

  bist_frame_seq #(
    .N_A1(N_A1), .N_A2(N_A2), .N_PAY(N_PAY), .A1(A1), .A2(A2)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .clr(clr), .adv(adv), .pay_byte(pay_byte),
    .byte_o(lane0), .pay_o(pay), .start_o(start)
  );

  bist_lane_skew #(.LANES(LANES), .W(8)) u_skew (
    .clk(clk), .rst_n(rst_n), .clr(clr), .adv(adv), .din(lane0), .dout(skewed)
  );

  assign out_valid = run_q;
  assign lane_data = run_q ? skewed : '0;
  assign out_sof   = run_q && start;
endmodule

// File: rtl/bist_frame_gen_chk.sv
module bist_frame_gen_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             test_n,
  input logic             frame_rst_n,
  input logic             out_ready,
  input logic             out_valid,
  input logic [LANES*8-1:0] lane_data,
  input logic             out_sof
);
  logic en;
  assign en = !test_n && frame_rst_n;

  p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> lane_data == '0);

  p_sof_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_valid);

  p_start_sof_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_sof);

  p_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> out_valid);

  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_rst_n |=> !out_valid);

  p_a1_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> lane_data[7:0] == 8'hF6);

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && en) |=> ($stable(lane_data) && $stable(out_sof)));

  p_stagger_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && en) |=> lane_data[15:8] == $past(lane_data[7:0]));
endmodule

bind bist_frame_gen bist_frame_gen_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .test_n(test_n), .frame_rst_n(frame_rst_n),
  .out_ready(out_ready), .out_valid(out_valid), .lane_data(lane_data),
  .out_sof(out_sof)
);

// File: tb/bist_frame_gen_bench.sv
module bist_frame_gen_bench;
  localparam int LANES = 4;
  localparam int FRAME = 9720;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, test_n, frame_rst_n, out_ready;
  logic out_valid, out_sof;
  logic [LANES*8-1:0] lane_data;

  bist_frame_gen u_bist_frame_gen (
    .clk(clk), .rst_n(rst_n), .test_n(test_n), .frame_rst_n(frame_rst_n),
    .out_ready(out_ready), .out_valid(out_valid), .lane_data(lane_data),
    .out_sof(out_sof)
  );

  int checks = 0;
  int errors = 0;

  // reference model
  int         m_pos;
  logic [6:0] m_lfsr;
  logic [7:0] m_dly [LANES];
  bit         m_first;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_pos = 0;
    m_lfsr = 7'h7F;
    m_first = 1'b1;
    for (int k = 0; k < LANES; k++) m_dly[k] = 8'h00;
  endtask

  function automatic logic [7:0] model_cur();
    logic [7:0] b;
    logic [6:0] s;
    if (m_pos < 12) return 8'hF6;
    if (m_pos < 24) return 8'h28;
    s = m_lfsr;
    for (int i = 0; i < 8; i++) begin
      b = {b[6:0], s[6] ^ s[5]};
      s = {s[5:0], s[6] ^ s[5]};
    end
    return b;
  endfunction

  task automatic model_advance();
    logic [7:0] cur;
    cur = model_cur();
    if (m_pos >= 24)
      for (int i = 0; i < 8; i++) m_lfsr = {m_lfsr[5:0], m_lfsr[6] ^ m_lfsr[5]};
    for (int k = LANES - 1; k > 1; k--) m_dly[k] = m_dly[k-1];
    m_dly[1] = cur;
    m_pos = (m_pos + 1) % FRAME;
    if (m_pos == 0) m_first = 1'b0;
  endtask

  task automatic check_beat(input bit stalled);
    logic [7:0] cur;
    cur = model_cur();
    chk("R2", out_valid, 1'b1);
    chk("R6", out_sof, m_pos == 0);
    if (stalled)          chk("R7", lane_data[7:0], cur);
    else if (m_pos < 24)  chk("R3", lane_data[7:0], cur);
    else                  chk("R4", lane_data[7:0], cur);
    if (m_first && m_pos == 24) chk("R4", lane_data[7:0], 8'h02);
    for (int k = 1; k < LANES; k++)
      chk(stalled ? "R7" : "R5", lane_data[k*8 +: 8], m_dly[k]);
  endtask

  // stall_mod 0: always ready; otherwise ready low on every stall_mod-th beat
  task automatic run_beats(input int nb, input int stall_mod);
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      check_beat(stall_mod != 0);
      out_ready = (stall_mod == 0) ? 1'b1 : ((i % stall_mod) != 0);
      if (out_ready) model_advance();
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; test_n = 1'b1; frame_rst_n = 1'b1; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", out_valid, 1'b0);
    chk("R1", out_sof, 1'b0);
    chk("R1", lane_data, '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9", out_valid, 1'b0);
    chk("R9", lane_data, '0);
  endtask

  task automatic t_full_rate();
    @(negedge clk);
    test_n = 1'b0;
    model_reset();
    run_beats(2 * FRAME + 50, 0);
  endtask

  task automatic t_stall();
    run_beats(FRAME + 120, 3);
  endtask

  task automatic t_frame_restart();
    @(negedge clk);
    out_ready = 1'b1;
    frame_rst_n = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk("R8", out_valid, 1'b0);
      chk("R9", lane_data, '0);
    end
    frame_rst_n = 1'b1;
    model_reset();
    @(negedge clk);
    chk("R8", out_sof, 1'b1);
    chk("R8", lane_data, {24'h000000, 8'hF6});
    model_advance();
    run_beats(40, 0);
  endtask

  task automatic t_disable();
    @(negedge clk);
    test_n = 1'b1;
    @(negedge clk);
    chk("R2", out_valid, 1'b0);
    chk("R6", out_sof, 1'b0);
    chk("R9", lane_data, '0);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    t_reset();
    t_full_rate();
    t_stall();
    t_frame_restart();
    t_disable();
    finish_run();
  end
endmodule